// File: doc/BRIEF.md
# Audio Reference Tick Generator with Fractional DTO

This block derives an audio reference tick from the pixel clock. It runs in the pixel clock domain and holds two fractional phase accumulators. Each accumulator adds a phase step on every clock. When the running sum reaches the modulo, it subtracts the modulo and marks a wrap with a single-cycle tick. The mean tick rate is therefore the pixel clock rate times phase over modulo.

Software supplies only the pixel clock rate in kHz, an encoder index and a mode flag. In a single write the configuration front end does three things:
- It sorts the rate into a bucket by its integer ratio to 24 MHz, which sets the phase step and a two-bit wallclock ratio code.
- It computes the modulo.
- It programs and selects one of the two accumulators.

In legacy mode a fixed phase is used instead, both values are scaled by one hundred, and the ratio code is left as it was.

Top module: `audio_dto_gen`

## Requirements
- R1: In normal mode a write picks the phase step from the ratio pixKhz/24000, using integer division: 192000 when the ratio is 8 or more, 96000 when it is 4 or more, 48000 when it is 2 or more, and 24000 otherwise. The ratio code on `wallRatio` becomes 3, 2, 1 or 0 respectively, starting in the cycle after the write.
- R2: In normal mode the modulo equals the pixel clock value in kHz.
- R3: In legacy mode the phase step is 2400000 and the modulo is pixKhz×100, truncated to 32 bits. `wallRatio` keeps its previous value.
- R4: An encoder index of 0 programs accumulator 0 and any other index programs accumulator 1. The written accumulator becomes the tick source, and `activeDto` shows 0 or 1 respectively from the cycle after the write until the next write.
- R5: On each clock edge with no write, the selected accumulator computes s = acc + phase. If s ≥ modulo, acc becomes s − modulo and `audioTick` is high for the following cycle; otherwise acc becomes s and `audioTick` is low.
- R6: A write clears the programmed accumulator to zero, and `audioTick` is low in the cycle after the write. Tick timing then restarts from zero, regardless of the old parameters.
- R7: When the selected modulo is zero, the accumulator holds and `audioTick` stays low.
- R8: When the phase step is greater than or equal to a nonzero modulo, `audioTick` is high in every cycle after the first edge that follows the write.
- R9: After reset `audioTick`, `wallRatio` and `activeDto` are all 0, and no tick is produced until a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | One-cycle configuration strobe |
| cfgPixKhz | input | 32 | Pixel clock rate in kHz |
| cfgEncIdx | input | 2 | Encoder index; 0 selects accumulator 0, other values select accumulator 1 |
| cfgLegacy | input | 1 | Selects the legacy scaling mode |
| audioTick | output | 1 | Wrap tick from the selected accumulator |
| wallRatio | output | 2 | Wallclock ratio code |
| activeDto | output | 1 | Index of the accumulator driving the tick |

## Verification
A wrong phase, modulo or accumulator value shows up as a tick pattern at `audioTick` that departs from the arithmetic model. The first wrap usually lands in the wrong cycle within a few clocks of the write. A stale accumulator that was not cleared on a write shifts the first tick relative to the zero-start pattern. A wrong bucket or selection is visible one cycle after the write on `wallRatio` or `activeDto`. The bench compares every cycle of a window against a model built from the requirements, so any divergence in sequence is caught at the first cycle where the tick differs.

// File: rtl/audio_dto_pkg.sv
package audio_dto_pkg;
  localparam int ACC_W   = 32;
  localparam int NUM_DTO = 2;
  localparam int CODE_W  = 2;

  localparam logic [ACC_W-1:0] BASE_STEP   = 32'd24000;
  localparam logic [ACC_W-1:0] LEGACY_STEP = 32'd2400000;
  localparam logic [ACC_W-1:0] LEGACY_MUL  = 32'd100;

  typedef struct packed {
    logic [NUM_DTO-1:0] load;
    logic [ACC_W-1:0]   phase;
    logic [ACC_W-1:0]   modulo;
  } dtoCmd_t;
endpackage

// File: rtl/audio_dto_ctrl.sv
module audio_dto_ctrl
  import audio_dto_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [ACC_W-1:0]  cfgPixKhz,
  input  logic [IDX_W-1:0]  cfgEncIdx,
  input  logic              cfgLegacy,
  output dtoCmd_t           cmd,
  output logic              selDto,
  output logic [CODE_W-1:0] wallRatio
);
  logic [CODE_W-1:0] bucketCode;
  logic [ACC_W-1:0]  bucketStep;
  logic              target;

  // Thresholds equal integer ratios 8, 4 and 2 against 24000 kHz.
  always_comb begin
    if (cfgPixKhz >= 32'd192000) begin
      bucketCode = 2'd3; bucketStep = BASE_STEP << 3;
    end else if (cfgPixKhz >= 32'd96000) begin
      bucketCode = 2'd2; bucketStep = BASE_STEP << 2;
    end else if (cfgPixKhz >= 32'd48000) begin
      bucketCode = 2'd1; bucketStep = BASE_STEP << 1;
    end else begin
      bucketCode = 2'd0; bucketStep = BASE_STEP;
    end
  end

  assign target = (cfgEncIdx != '0);

  always_comb begin
    cmd = '0;
    if (cfgWrite) cmd.load[target] = 1'b1;
    if (cfgLegacy) begin
      cmd.phase  = LEGACY_STEP;
      cmd.modulo = cfgPixKhz * LEGACY_MUL;
    end else begin
      cmd.phase  = bucketStep;
      cmd.modulo = cfgPixKhz;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selDto    <= 1'b0;
      wallRatio <= '0;
    end else if (cfgWrite) begin
      selDto <= target;
      if (!cfgLegacy) wallRatio <= bucketCode;
    end
  end
endmodule

// File: rtl/audio_dto_acc.sv
module audio_dto_acc
  import audio_dto_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [ACC_W-1:0] newPhase,
  input  logic [ACC_W-1:0] newModulo,
  output logic             tick
);
  logic [ACC_W-1:0] phaseReg, modReg, accReg;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, accReg} + {1'b0, phaseReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseReg <= '0;
      modReg   <= '0;
      accReg   <= '0;
      tick     <= 1'b0;
    end else if (load) begin
      phaseReg <= newPhase;
      modReg   <= newModulo;
      accReg   <= '0;
      tick     <= 1'b0;
    end else if (modReg == '0) begin
      tick <= 1'b0;
    end else if (phaseReg >= modReg) begin
      accReg <= '0;
      tick   <= 1'b1;
    end else if (sum >= {1'b0, modReg}) begin
      accReg <= ACC_W'(sum - {1'b0, modReg});
      tick   <= 1'b1;
    end else begin
      accReg <= sum[ACC_W-1:0];
      tick   <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_dto_datapath.sv
module audio_dto_datapath
  import audio_dto_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dtoCmd_t cmd,
  input  logic    selDto,
  output logic    audioTick
);
  logic [NUM_DTO-1:0] ticks;

  for (genvar g = 0; g < NUM_DTO; g++) begin : gDto
    audio_dto_acc acc_i (
      .clk       (clk),
      .rstN      (rstN),
      .load      (cmd.load[g]),
      .newPhase  (cmd.phase),
      .newModulo (cmd.modulo),
      .tick      (ticks[g])
    );
  end

  assign audioTick = ticks[selDto];
endmodule

// File: rtl/audio_dto_gen.sv
module audio_dto_gen
  import audio_dto_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [31:0]       cfgPixKhz,
  input  logic [IDX_W-1:0]  cfgEncIdx,
  input  logic              cfgLegacy,
  output logic              audioTick,
  output logic [1:0]        wallRatio,
  output logic              activeDto
);
  dtoCmd_t cmd;

  audio_dto_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrite  (cfgWrite),
    .cfgPixKhz (cfgPixKhz),
    .cfgEncIdx (cfgEncIdx),
    .cfgLegacy (cfgLegacy),
    .cmd       (cmd),
    .selDto    (activeDto),
    .wallRatio (wallRatio)
  );

  audio_dto_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .selDto    (activeDto),
    .audioTick (audioTick)
  );
endmodule

// File: rtl/audio_dto_checker.sv
module audio_dto_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrite,
  input logic [31:0]      cfgPixKhz,
  input logic [IDX_W-1:0] cfgEncIdx,
  input logic             cfgLegacy,
  input logic             audioTick,
  input logic [1:0]       wallRatio,
  input logic             activeDto
);
  logic zeroModSel;

  always_ff @(posedge clk) begin
    if (!rstN) zeroModSel <= 1'b1;
    else if (cfgWrite) zeroModSel <= (cfgPixKhz == 32'd0);
  end

  AST_TOP_BUCKET: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && !cfgLegacy && cfgPixKhz >= 32'd192000 |=> wallRatio == 2'd3); // R1
  AST_LOW_BUCKET: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && !cfgLegacy && cfgPixKhz < 32'd48000 |=> wallRatio == 2'd0); // R1
  AST_LEGACY_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite && cfgLegacy |=> $stable(wallRatio)); // R3
  AST_SELECT_FOLLOWS_IDX: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> activeDto == ($past(cfgEncIdx) != '0)); // R4
  AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> $stable(activeDto)); // R4
  AST_WRITE_QUIETS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !audioTick); // R6
  AST_ZERO_MOD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    zeroModSel |-> !audioTick); // R7
endmodule

bind audio_dto_gen audio_dto_checker #(.IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrite  (cfgWrite),
  .cfgPixKhz (cfgPixKhz),
  .cfgEncIdx (cfgEncIdx),
  .cfgLegacy (cfgLegacy),
  .audioTick (audioTick),
  .wallRatio (wallRatio),
  .activeDto (activeDto)
);

// File: tb/audio_dto_gen_tb_top.sv
`timescale 1ns/1ps
module audio_dto_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] cfgPixKhz = '0;
  logic [1:0]  cfgEncIdx = '0;
  logic        cfgLegacy = 1'b0;
  logic        audioTick;
  logic [1:0]  wallRatio;
  logic        activeDto;

  int nChecks = 0;
  int nFails  = 0;
  logic [1:0] lastCode = 2'd0;

  always #5 clk = ~clk;

  audio_dto_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgPixKhz(cfgPixKhz),
    .cfgEncIdx(cfgEncIdx), .cfgLegacy(cfgLegacy),
    .audioTick(audioTick), .wallRatio(wallRatio), .activeDto(activeDto)
  );

  task automatic check(input string req, input longint act, input longint exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Writes one configuration, then checks R1/R3/R4/R6 and runs the tick model (R5/R7/R8).
  task automatic runCase(input string req, input longint pix, input bit legacy,
                         input logic [1:0] idx, input int cycles);
    longint ratio, phase, modv, acc, s;
    logic [1:0] code;
    int bad;
    ratio = pix / 24000;
    if (legacy) begin
      phase = 2400000; modv = (pix * 100) & 64'hFFFF_FFFF; code = lastCode;
    end else begin
      modv = pix;
      if (ratio >= 8)      begin phase = 192000; code = 2'd3; end
      else if (ratio >= 4) begin phase = 96000;  code = 2'd2; end
      else if (ratio >= 2) begin phase = 48000;  code = 2'd1; end
      else                 begin phase = 24000;  code = 2'd0; end
    end
    lastCode = code;
    @(negedge clk);
    cfgWrite = 1'b1; cfgPixKhz = 32'(pix); cfgLegacy = legacy; cfgEncIdx = idx;
    @(negedge clk);
    cfgWrite = 1'b0;
    check("R1/R3", wallRatio, code, {req, " ratio code"});
    check("R4", activeDto, (idx != 0), {req, " selected accumulator"});
    check("R6", audioTick, 0, {req, " tick after write"});
    acc = 0; bad = 0;
    for (int c = 0; c < cycles; c++) begin
      logic expTick;
      @(negedge clk);
      if (modv == 0) expTick = 1'b0;
      else if (phase >= modv) begin expTick = 1'b1; acc = 0; end
      else begin
        s = acc + phase;
        if (s >= modv) begin expTick = 1'b1; acc = s - modv; end
        else begin expTick = 1'b0; acc = s; end
      end
      if (audioTick !== expTick && bad == 0) begin
        bad = 1;
        $display("FAIL R5 %s tick at cycle %0d: actual %0b expected %0b", req, c, audioTick, expTick);
      end
    end
    nChecks++;
    if (bad != 0) nFails++;
  endtask

  task automatic testReset();
    check("R9", audioTick, 0, "tick after reset");
    check("R9", wallRatio, 0, "ratio code after reset");
    check("R9", activeDto, 0, "selection after reset");
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (audioTick !== 1'b0) begin
        check("R9", audioTick, 0, "tick before any write");
        break;
      end
    end
  endtask

  initial begin : watchdog
    #500000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runCase("R1 R2 ratio6",        148500, 1'b0, 2'd0, 60);
    runCase("R1 R2 ratio1",        27000,  1'b0, 2'd0, 40);
    runCase("R1 ratio8 top",       200000, 1'b0, 2'd1, 40);
    runCase("R1 R8 edge48000",     48000,  1'b0, 2'd1, 20);
    runCase("R1 edge47999",        47999,  1'b0, 2'd0, 40);
    runCase("R1 R8 edge192000",    192000, 1'b0, 2'd0, 20);
    runCase("R1 edge191999",       191999, 1'b0, 2'd2, 40);
    runCase("R8 slow pixel",       10000,  1'b0, 2'd3, 20);
    runCase("R3 legacy",           74250,  1'b1, 2'd0, 60);
    runCase("R3 legacy dto1",      25175,  1'b1, 2'd1, 60);
    runCase("R7 zero modulo",      0,      1'b0, 2'd0, 30);
    runCase("R6 R4 reprogram",     108000, 1'b0, 2'd2, 15);
    runCase("R6 restart mid-run",  108000, 1'b0, 2'd2, 50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule